// File: doc/BRIEF.md
# Multicycle 16-bit Register Machine Core

This block is a small processor core with 16-bit words, 16-bit addresses and eight 16-bit general registers. Each instruction is walked through a fixed series of phases: fetch, decode, address evaluation, operand fetch, execute and result store. A phase sequencer drops the phases that an opcode does not use, so different instruction kinds take different numbers of clocks. The instruction set is register ADD, AND and NOT, a load and a store that address memory as a base register plus a signed offset, a jump through a register, and a branch that tests condition flags.

The core reaches memory only through two internal registers: an address holder driven out on `mem_addr` and a data holder driven out on `mem_wdata`. A one-cycle read strobe or write strobe marks each access. The memory must return read data on `mem_rdata` in the clock after the read strobe. The core captures that word in the next clock edge. Instruction fetch and data loads use the same port.

Top module: `mc16_core`

## Requirements
- R1: While `rst` is high, both strobes stay low. Reset clears the PC and all eight registers to 0x0000 and sets the Z flag, so the first read strobe after reset carries address 0x0000 and a `BRz` at that address is taken.
- R2: Each instruction starts with a read strobe whose address is the PC. An instruction that is not a taken branch or a jump is followed by a fetch at PC+1.
- R3: `mem_rd` and `mem_wr` are never high in the same cycle.
- R4: Opcode 0001 (ADD) writes the 16-bit sum of register [8:6] and register [2:0] to register [11:9]. The carry is discarded.
- R5: Opcode 0101 (AND) writes the bitwise AND of register [8:6] and register [2:0] to register [11:9].
- R6: Opcode 1001 (NOT) writes the bitwise complement of register [8:6] to register [11:9].
- R7: Opcode 0110 (load) issues a read strobe at register [8:6] plus the sign-extended bits [5:0]. It writes the returned word to register [11:9].
- R8: Opcode 0111 (store) issues exactly one write strobe. The address is register [8:6] plus the sign-extended bits [5:0], and the data is register [11:9]. No other opcode raises `mem_wr`.
- R9: Opcode 0000 (branch) moves the PC to PC+1 plus the sign-extended bits [8:0] when at least one of the following holds: bit 11 and the N flag are both set, bit 10 and the Z flag are both set, or bit 9 and the P flag are both set. Otherwise execution continues at PC+1.
- R10: Opcode 1100 (jump) loads the PC from register [8:6].
- R11: Every register write from ADD, AND, NOT or a load sets exactly one of N, Z and P to match the sign of the written word. Stores, branches and jumps leave the flags unchanged.
- R12: The clocks from one fetch strobe to the next are as follows: ADD, AND and NOT take 8, a load takes 9, a store takes 8, a branch takes 7 and a jump takes 6. Any other opcode takes 5 clocks and changes no state except the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Contents of the memory address register |
| mem_rd | output | 1 | Read strobe, one cycle per access |
| mem_wr | output | 1 | Write strobe, one cycle per store |
| mem_wdata | output | 16 | Contents of the memory data register |
| mem_rdata | input | 16 | Read data, valid the clock after `mem_rd` |

## Verification
The assertions assume that `rst` is held for at least one clock edge. They also assume that `mem_rdata` carries the addressed word in the cycle after every read strobe, because the fetch and load phases latch it there without a handshake. The bench keeps to this with a memory model that registers its output on the strobe edge. The test program and its data stay inside a 256-word window, so every address the core forms lands on modelled storage.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

    localparam int XLEN = 16;
    localparam int NREG = 8;
    localparam int RIDX = $clog2(NREG);

    typedef logic [XLEN-1:0] word_t;
    typedef logic [RIDX-1:0] ridx_t;

    typedef enum logic [3:0] {
        OPC_BR  = 4'b0000,
        OPC_ADD = 4'b0001,
        OPC_AND = 4'b0101,
        OPC_LDR = 4'b0110,
        OPC_STR = 4'b0111,
        OPC_NOT = 4'b1001,
        OPC_JMP = 4'b1100
    } opc_e;

    typedef enum logic [3:0] {
        PH_F0, PH_F1, PH_F2, PH_F3, PH_D,
        PH_EA, PH_OP1, PH_OP2, PH_EX, PH_S1, PH_S2
    } phase_e;

    typedef enum logic [1:0] {
        ALU_ADD, ALU_AND, ALU_NOT, ALU_PASS
    } alu_op_e;

    typedef struct packed {
        ridx_t   dr;
        ridx_t   sr1;
        ridx_t   sr2;
        word_t   off6;
        word_t   off9;
        logic [2:0] cmask;
        logic    is_alu;
        logic    is_ldr;
        logic    is_str;
        logic    is_br;
        logic    is_jmp;
        alu_op_e aop;
    } dec_t;

    function automatic word_t sext6(input logic [5:0] f);
        return {{(XLEN-6){f[5]}}, f};
    endfunction

    function automatic word_t sext9(input logic [8:0] f);
        return {{(XLEN-9){f[8]}}, f};
    endfunction

    // flags ordered {N, Z, P}
    function automatic logic [2:0] sign_flags(input word_t w);
        if (w[XLEN-1])   return 3'b100;
        else if (w == '0) return 3'b010;
        else              return 3'b001;
    endfunction

endpackage

// File: rtl/mc16_decode.sv
module mc16_decode
    import mc16_pkg::*;
(
    input  word_t        ir,
    output logic [15:0]  op_hot,
    output dec_t         dec
);
    always_comb begin
        op_hot = 16'b1 << ir[15:12];
        dec.dr     = ir[11:9];
        dec.sr1    = ir[8:6];
        dec.sr2    = ir[2:0];
        dec.off6   = sext6(ir[5:0]);
        dec.off9   = sext9(ir[8:0]);
        dec.cmask  = ir[11:9];
        dec.is_alu = op_hot[OPC_ADD] | op_hot[OPC_AND] | op_hot[OPC_NOT];
        dec.is_ldr = op_hot[OPC_LDR];
        dec.is_str = op_hot[OPC_STR];
        dec.is_br  = op_hot[OPC_BR];
        dec.is_jmp = op_hot[OPC_JMP];
        if (op_hot[OPC_ADD])      dec.aop = ALU_ADD;
        else if (op_hot[OPC_AND]) dec.aop = ALU_AND;
        else if (op_hot[OPC_NOT]) dec.aop = ALU_NOT;
        else                      dec.aop = ALU_PASS;
    end
endmodule

// File: rtl/mc16_regfile.sv
module mc16_regfile
    import mc16_pkg::*;
#(
    parameter int N = NREG,
    parameter int W = XLEN,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [W-1:0]  rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && waddr == AW'(g))
                regs[g] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/mc16_alu.sv
module mc16_alu
    import mc16_pkg::*;
(
    input  alu_op_e op,
    input  word_t   a,
    input  word_t   b,
    output word_t   y
);
    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_AND:  y = a & b;
            ALU_NOT:  y = ~a;
            default:  y = a;
        endcase
    end
endmodule

// File: rtl/mc16_seq.sv
module mc16_seq
    import mc16_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  dec_t   dec,
    output phase_e phase
);
    phase_e nxt;

    always_comb begin
        nxt = PH_F0;
        unique case (phase)
            PH_F0: nxt = PH_F1;
            PH_F1: nxt = PH_F2;
            PH_F2: nxt = PH_F3;
            PH_F3: nxt = PH_D;
            PH_D: begin
                if (dec.is_alu)                              nxt = PH_OP1;
                else if (dec.is_ldr | dec.is_str | dec.is_br) nxt = PH_EA;
                else if (dec.is_jmp)                         nxt = PH_S1;
                else                                         nxt = PH_F0;
            end
            PH_EA:  nxt = dec.is_ldr ? PH_OP1 : PH_S1;
            PH_OP1: nxt = dec.is_ldr ? PH_OP2 : PH_EX;
            PH_OP2: nxt = PH_S1;
            PH_EX:  nxt = PH_S1;
            PH_S1:  nxt = dec.is_str ? PH_S2 : PH_F0;
            PH_S2:  nxt = PH_F0;
            default: nxt = PH_F0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_F0;
        else     phase <= nxt;
    end
endmodule

// File: rtl/mc16_core.sv
module mc16_core
    import mc16_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] mem_addr,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata
);
    word_t       pc, ir, mar, mdr, opa, opb, res, tgt;
    logic [2:0]  cc;
    phase_e      phase;
    dec_t        dec;
    logic [15:0] op_hot;
    word_t       rd_a, rd_b, alu_y, wb_data;
    ridx_t       rb_sel;
    logic        rf_we, br_take;

    mc16_decode u_dec (.ir(ir), .op_hot(op_hot), .dec(dec));

    mc16_seq u_seq (.clk(clk), .rst(rst), .dec(dec), .phase(phase));

    assign rb_sel = dec.is_str ? dec.dr : dec.sr2;
    assign rf_we  = (phase == PH_S1) && (dec.is_alu || dec.is_ldr);
    assign wb_data = dec.is_ldr ? mdr : res;

    mc16_regfile #(.N(NREG), .W(XLEN)) u_rf (
        .clk(clk), .rst(rst),
        .we(rf_we), .waddr(dec.dr), .wdata(wb_data),
        .raddr_a(dec.sr1), .rdata_a(rd_a),
        .raddr_b(rb_sel),  .rdata_b(rd_b)
    );

    mc16_alu u_alu (.op(dec.aop), .a(opa), .b(opb), .y(alu_y));

    assign br_take = |(dec.cmask & cc);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            ir  <= '0;
            mar <= '0;
            mdr <= '0;
            opa <= '0;
            opb <= '0;
            res <= '0;
            tgt <= '0;
            cc  <= 3'b010;
        end else begin
            unique case (phase)
                PH_F0: mar <= pc;
                PH_F2: mdr <= mem_rdata;
                PH_F3: begin
                    ir <= mdr;
                    pc <= pc + word_t'(1);
                end
                PH_EA: begin
                    if (dec.is_br) tgt <= pc + dec.off9;
                    else           mar <= rd_a + dec.off6;
                end
                PH_OP1: begin
                    opa <= rd_a;
                    opb <= rd_b;
                end
                PH_OP2: mdr <= mem_rdata;
                PH_EX:  res <= alu_y;
                PH_S1: begin
                    if (rf_we)                  cc  <= sign_flags(wb_data);
                    if (dec.is_str)             mdr <= rd_b;
                    if (dec.is_br && br_take)   pc  <= tgt;
                    if (dec.is_jmp)             pc  <= rd_a;
                end
                default: ;
            endcase
        end
    end

    assign mem_addr  = mar;
    assign mem_wdata = mdr;
    assign mem_rd    = (phase == PH_F1) || (phase == PH_OP1 && dec.is_ldr);
    assign mem_wr    = (phase == PH_S2);
endmodule

// File: rtl/mc16_core_chk.sv
module mc16_core_chk
    import mc16_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input phase_e     phase,
    input word_t      pc,
    input word_t      ir,
    input logic [2:0] cc,
    input logic       rf_we,
    input logic       mem_rd,
    input logic       mem_wr,
    input word_t      mem_addr
);
    assert_rdwr_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_F1) |-> (mem_rd && mem_addr == pc));

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_F3) |=> (pc == $past(pc) + 16'd1));

    assert_cc_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $countones(cc) == 1);

    assert_cc_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !rf_we |=> $stable(cc));

    assert_wr_store_R8: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (ir[15:12] == 4'b0111));

    assert_wr_last_R12: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> (phase == PH_F0));
endmodule

bind mc16_core mc16_core_chk chk_i (
    .clk(clk), .rst(rst), .phase(phase), .pc(pc), .ir(ir), .cc(cc),
    .rf_we(rf_we), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr)
);

// File: tb/mc16_core_tb.sv
module mc16_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    mc16_core dut_i (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // ---- program encoders ----
    function automatic logic [15:0] e_rrr(input logic [3:0] op, input int d, input int a, input int b);
        return {op, 3'(d), 3'(a), 3'b000, 3'(b)};
    endfunction
    function automatic logic [15:0] e_not(input int d, input int a);
        return {4'b1001, 3'(d), 3'(a), 6'b111111};
    endfunction
    function automatic logic [15:0] e_mem(input logic [3:0] op, input int d, input int b, input int off);
        return {op, 3'(d), 3'(b), 6'(off)};
    endfunction
    function automatic logic [15:0] e_br(input logic [2:0] m, input int off);
        return {4'b0000, m, 9'(off)};
    endfunction
    function automatic logic [15:0] e_jmp(input int b);
        return {4'b1100, 3'b000, 3'(b), 6'b0};
    endfunction

    function automatic logic [15:0] init_word(input int a);
        case (a)
            0:  return e_br(3'b010, 1);            // reset Z -> taken
            1:  return e_mem(4'b0111, 0, 0, 30);   // skipped store
            2:  return e_mem(4'b0110, 7, 0, 31);   // R7 = 0x0080
            3:  return e_mem(4'b0110, 1, 7, 0);    // R1 = 0x7FFF
            4:  return e_mem(4'b0110, 2, 7, 1);    // R2 = 0x0001
            5:  return e_rrr(4'b0001, 3, 1, 2);    // R3 = 0x8000
            6:  return e_mem(4'b0111, 3, 7, 8);    // [0x88] = R3
            7:  return e_br(3'b100, 1);            // taken
            8:  return e_mem(4'b0111, 1, 7, 9);    // skipped
            9:  return e_rrr(4'b0001, 4, 3, 3);    // R4 = 0 (carry lost)
            10: return e_br(3'b010, 1);            // taken
            11: return e_mem(4'b0111, 1, 7, 9);    // skipped
            12: return e_br(3'b101, 5);            // not taken
            13: return e_mem(4'b0110, 5, 7, 2);
            14: return e_mem(4'b0110, 6, 7, 3);
            15: return e_rrr(4'b0101, 5, 5, 6);    // R5 = 0x00F0
            16: return e_mem(4'b0111, 5, 7, 10);   // [0x8A]
            17: return e_not(6, 5);                // R6 = 0xFF0F
            18: return e_mem(4'b0111, 6, 7, -1);   // [0x7F]
            19: return e_br(3'b001, -3);           // not taken
            20: return e_mem(4'b0110, 1, 7, 11);   // R1 = 0x0040
            21: return e_jmp(1);
            31: return 16'h0080;
            64: return e_rrr(4'b0001, 2, 2, 2);    // R2 = 2
            65: return e_mem(4'b0110, 3, 7, 8);    // R3 = [0x88]
            66: return e_mem(4'b0111, 3, 7, 12);   // [0x8C]
            67: return 16'hD000;                   // unused opcode
            68: return e_br(3'b111, -2);           // spin to 67
            128: return 16'h7FFF;
            129: return 16'h0001;
            130: return 16'hF0F0;
            131: return 16'h0FF0;
            139: return 16'h0040;
            default: return 16'h0000;
        endcase
    endfunction

    // ---- memory model: data one clock after the strobe ----
    logic [15:0] mem [256];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_word(i);
            mem_rdata <= '0;
        end else begin
            if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
            if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // ---- behavioural reference ----
    logic [15:0] rr [8];
    logic [15:0] refmem [256];
    logic [2:0]  rcc;
    logic [15:0] rpc, f_addr, ea, wd;
    int          lat, off, ninstr;
    bit          rd2, wr;
    string       optag, ftag, prevtag;

    function automatic logic [2:0] flags(input logic [15:0] w);
        return w[15] ? 3'b100 : (w == 0 ? 3'b010 : 3'b001);
    endfunction

    task automatic ref_step();
        logic [15:0] ins, o6, o9;
        int d, a, b;
        ins = refmem[rpc[7:0]];
        f_addr = rpc;
        ftag = (ninstr == 0) ? "R1" : prevtag;
        rpc = rpc + 16'd1;
        d = int'(ins[11:9]); a = int'(ins[8:6]); b = int'(ins[2:0]);
        o6 = {{10{ins[5]}}, ins[5:0]};
        o9 = {{7{ins[8]}}, ins[8:0]};
        rd2 = 0; wr = 0; prevtag = "R2";
        case (ins[15:12])
            4'b0001: begin lat = 8; rr[d] = rr[a] + rr[b]; rcc = flags(rr[d]); optag = "R4"; end
            4'b0101: begin lat = 8; rr[d] = rr[a] & rr[b]; rcc = flags(rr[d]); optag = "R5"; end
            4'b1001: begin lat = 8; rr[d] = ~rr[a];        rcc = flags(rr[d]); optag = "R6"; end
            4'b0110: begin
                lat = 9; ea = rr[a] + o6; rd2 = 1;
                rr[d] = refmem[ea[7:0]]; rcc = flags(rr[d]); optag = "R7";
            end
            4'b0111: begin
                lat = 8; ea = rr[a] + o6; wr = 1; wd = rr[d];
                refmem[ea[7:0]] = wd; optag = "R8";
            end
            4'b0000: begin
                lat = 7; optag = "R9";
                if (|(ins[11:9] & rcc)) rpc = rpc + o9;
                prevtag = "R9 R11";
            end
            4'b1100: begin lat = 6; rpc = rr[a]; optag = "R10"; prevtag = "R10"; end
            default: begin lat = 5; optag = "R12"; end
        endcase
        ninstr++;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) rr[i] = '0;
        for (int i = 0; i < 256; i++) refmem[i] = init_word(i);
        rcc = 3'b010; rpc = '0; off = 0; ninstr = 0; prevtag = "R2";
        repeat (4) @(negedge clk);
        check("R1", "mem_rd in reset", {15'b0, mem_rd}, 16'd0);
        check("R1", "mem_wr in reset", {15'b0, mem_wr}, 16'd0);
        rst = 1'b0;
        for (int cyc = 0; cyc < 420; cyc++) begin
            bit er, ew;
            if (off == 0) ref_step();
            er = (off == 1) || (rd2 && off == 6);
            ew = wr && (off == 7);
            check("R3", "strobe overlap", {15'b0, mem_rd & mem_wr}, 16'd0);
            check("R12", {optag, " read strobe"}, {15'b0, mem_rd}, {15'b0, er});
            check("R12", {optag, " write strobe"}, {15'b0, mem_wr}, {15'b0, ew});
            if (er && off == 1) check(ftag, "fetch address", mem_addr, f_addr);
            if (er && off == 6) check("R7", "load address", mem_addr, ea);
            if (ew) begin
                check("R8", "store address", mem_addr, ea);
                check(optag == "R8" ? "R8" : optag, "store data", mem_wdata, wd);
            end
            off++;
            if (off == lat) off = 0;
            @(negedge clk);
        end
        check("R4", "ADD overflow stored at 0x88", mem[8'h88], 16'h8000);
        check("R9", "skipped store left 0x89", mem[8'h89], 16'h0000);
        check("R1", "skipped store left 0x1E", mem[8'h1E], 16'h0000);
        check("R5", "AND result at 0x8A", mem[8'h8A], 16'h00F0);
        check("R6", "NOT result at 0x7F", mem[8'h7F], 16'hFF0F);
        check("R7", "reloaded word at 0x8C", mem[8'h8C], 16'h8000);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule